// File: doc/BRIEF.md
# Triple-Redundant Sequencer with Self-Disabling Pad Drivers

This block holds three identical copies of a small counting sequencer. Each copy has its own clock, its own synchronous reset and its own start pin. Together they form one radiation-tolerant function. On every edge, a copy computes its next state from the bitwise majority of all three copies' registered states. A copy whose register was flipped therefore falls back into step on the next edge of its own clock.

Each copy presents its registered state on its own group of output pads, together with an output enable for the tristate pad cell. The three pad groups are meant to be joined by board traces. A per-domain minority check drops a copy's enable while its value disagrees with both of the others, so the joined trace always carries the value that at least two copies agree on. A sticky per-domain flag records that the copy was ever out of step with the vote.

The sequencer itself waits in an idle phase until its synchronised start input is high. It then counts from zero up to a parameterised last value, spends one cycle in a done phase and returns to idle. All storage is ordinary edge-triggered flip-flops.

Top module: `tmr_wrapper`

## Requirements
- R1: While a domain's reset input is low at its clock edge, that domain's pad value becomes 0, its flag clears, and once all domains are reset every output enable is high.
- R2: A start pin sampled high at edge k of its domain is seen by that copy after a two-flop synchroniser, so the copy enters the running phase with count 0 at edge k+2.
- R3: The pad value is {phase[1:0], count[CNT_W-1:0]} with idle=0, running=1, done=2. In the running phase the count rises by one per edge up to LAST. The copy then holds done with count LAST for exactly one edge and returns to idle with count 0.
- R4: Each copy's next state is computed from the bitwise majority of the three registered states, so a copy whose register alone was altered matches the others again after its next clock edge.
- R5: A domain's output enable is low exactly when its pad value differs from both other domains' pad values.
- R6: When all three pad values are distinct, all three enables are low. Two enabled domains never present different values.
- R7: A domain's flag sets at the edge where its own registered state differs from the majority state. It stays set until that domain's reset.
- R8: A start pulse seen on one domain's pin only moves that copy for a single cycle. During that cycle its enable is low, and the joined trace keeps the agreed value.
- R9: The start input has no effect outside the idle phase: a start pulse during counting leaves the count sequence unchanged and the block returns to idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_dom | input | 3 | One clock per redundant domain |
| rst_dom_n | input | 3 | Per-domain synchronous active-low reset |
| start_pin | input | 3 | Per-domain start request pin, asynchronous to the domain |
| pad_val | output | 3 x (2+CNT_W) | Per-domain data for its tristate pad group |
| pad_oe | output | 3 | Per-domain tristate enable, low while the domain is in the minority |
| upset_flag | output | 3 | Sticky per-domain out-of-step flag |

## Verification
Two functions can land in the same cycle: a single-copy register upset and the sequencer's own phase change at the end of the count. The bench flips one copy's count in the cycle where the vote reads running with count LAST. It then expects the trace to hold that value, and the copy to move into done together with the others on the following edge, which shows that the vote rather than the corrupted register chose the transition. A second case flips two copies at once to distinct values: all enables must fall together, and the majority must still rebuild the right state.

// File: rtl/tmr_pkg.sv
// Shared definitions for the triple-redundant sequencer.
// Assumes exactly three redundant domains.
package tmr_pkg;
    localparam int NDOM = 3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_t;
endpackage

// File: rtl/tmr_sync2.sv
// Two-flop synchroniser for one asynchronous input bit.
// Assumes the input is a slow level; no pulse stretching is done.
module tmr_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    // Capture the pin, then re-register it to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/tmr_voter.sv
// Bitwise two-of-three majority of three equal-width words.
// Purely combinational; each domain owns a private instance.
module tmr_voter #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] y
);
    // Each output bit follows whichever value two inputs share.
    assign y = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/tmr_minority.sv
// Minority detector driving one domain's tristate enable.
// The enable drops only when the own value matches neither peer.
module tmr_minority #(
    parameter int W = 8
) (
    input  logic [W-1:0] own,
    input  logic [W-1:0] peer_x,
    input  logic [W-1:0] peer_y,
    output logic         oe
);
    logic differs_x;
    logic differs_y;

    // Compare against each peer separately.
    assign differs_x = (own != peer_x);
    assign differs_y = (own != peer_y);
    // Keep driving unless outvoted by both peers.
    assign oe = !(differs_x && differs_y);
endmodule

// File: rtl/tmr_copy.sv
// One redundant copy of the counting sequencer, clocked by its own domain.
// Next state comes from the majority of all three copies' registers, so
// a copy with a corrupted register realigns on its next edge.
// Assumes 2 <= LAST < 2**CNT_W.
module tmr_copy
    import tmr_pkg::*;
#(
    parameter  int CNT_W = 4,
    parameter  int LAST  = 5,
    localparam int SW    = 2 + CNT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_pin,
    input  logic [NDOM-1:0][SW-1:0]  all_state,
    output logic [SW-1:0]            state_q,
    output logic                     upset_q
);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LAST);

    logic             start_s;
    logic [SW-1:0]    voted;
    phase_t           v_phase;
    logic [CNT_W-1:0] v_cnt;
    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;
    phase_t           nxt_phase;
    logic [CNT_W-1:0] nxt_cnt;

    tmr_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (start_pin),
        .q     (start_s)
    );

    tmr_voter #(.W(SW)) u_vote (
        .a (all_state[0]),
        .b (all_state[1]),
        .c (all_state[2]),
        .y (voted)
    );

    assign v_phase = phase_t'(voted[SW-1 -: 2]);
    assign v_cnt   = voted[CNT_W-1:0];
    assign state_q = {phase_q, cnt_q};

    // Sequencer transition computed from the voted state only.
    always_comb begin
        nxt_phase = PH_IDLE;
        nxt_cnt   = '0;
        case (v_phase)
            PH_IDLE: begin
                if (start_s) nxt_phase = PH_RUN;
            end
            PH_RUN: begin
                if (v_cnt == LAST_C) begin
                    nxt_phase = PH_DONE;
                    nxt_cnt   = v_cnt;
                end else begin
                    nxt_phase = PH_RUN;
                    nxt_cnt   = v_cnt + 1'b1;
                end
            end
            default: begin
                nxt_phase = PH_IDLE;
            end
        endcase
    end

    // State registers of this copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= nxt_phase;
            cnt_q   <= nxt_cnt;
        end
    end

    // Sticky record of any disagreement between own register and the vote.
    always_ff @(posedge clk) begin
        if (!rst_n) upset_q <= 1'b0;
        else        upset_q <= upset_q | (state_q != voted);
    end
endmodule

// File: rtl/tmr_wrapper.sv
// Top of the triple-redundant sequencer. Three copies run in three clock
// domains; each feeds its own pad group with an enable that a private
// minority detector controls. Pads are joined on the board, not on chip.
module tmr_wrapper
    import tmr_pkg::*;
#(
    parameter  int CNT_W = 4,
    parameter  int LAST  = 5,
    localparam int OUT_W = 2 + CNT_W
) (
    input  logic [NDOM-1:0]             clk_dom,
    input  logic [NDOM-1:0]             rst_dom_n,
    input  logic [NDOM-1:0]             start_pin,
    output logic [NDOM-1:0][OUT_W-1:0]  pad_val,
    output logic [NDOM-1:0]             pad_oe,
    output logic [NDOM-1:0]             upset_flag
);
    logic [NDOM-1:0][OUT_W-1:0] st;

    for (genvar i = 0; i < NDOM; i++) begin : g_dom
        tmr_copy #(.CNT_W(CNT_W), .LAST(LAST)) u_copy (
            .clk       (clk_dom[i]),
            .rst_n     (rst_dom_n[i]),
            .start_pin (start_pin[i]),
            .all_state (st),
            .state_q   (st[i]),
            .upset_q   (upset_flag[i])
        );

        tmr_minority #(.W(OUT_W)) u_min (
            .own    (st[i]),
            .peer_x (st[(i + 1) % NDOM]),
            .peer_y (st[(i + 2) % NDOM]),
            .oe     (pad_oe[i])
        );

        assign pad_val[i] = st[i];
    end
endmodule

// File: rtl/tmr_wrapper_chk.sv
// Property checker for tmr_wrapper, sampled on domain 0's clock.
// Assumes the domains run at the same frequency.
module tmr_wrapper_chk
    import tmr_pkg::*;
#(
    parameter  int CNT_W = 4,
    parameter  int LAST  = 5,
    localparam int OUT_W = 2 + CNT_W
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NDOM-1:0][OUT_W-1:0]      pad_val,
    input logic [NDOM-1:0]                 pad_oe,
    input logic [NDOM-1:0]                 upset_flag
);
    logic all_eq;
    assign all_eq = (pad_val[0] == pad_val[1]) && (pad_val[1] == pad_val[2]);

    // R6: enabled pads never fight on the joined trace.
    p_no_clash01_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[0] && pad_oe[1]) |-> (pad_val[0] == pad_val[1]));
    p_no_clash12_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[1] && pad_oe[2]) |-> (pad_val[1] == pad_val[2]));
    p_no_clash02_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[0] && pad_oe[2]) |-> (pad_val[0] == pad_val[2]));

    // R5: an agreeing pair always keeps both drivers on.
    p_pair_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_val[1] == pad_val[2]) |-> (pad_oe[1] && pad_oe[2]));

    // R7: the flag never clears on its own.
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upset_flag[0] |=> upset_flag[0]);

    // R3: an agreed count never exceeds the last value.
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[0] && pad_oe[1]) |-> (pad_val[0][CNT_W-1:0] <= CNT_W'(LAST)));

    // R3: an agreed done phase lasts one edge.
    p_done_to_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (all_eq && pad_val[0][OUT_W-1 -: 2] == 2'd2) |=> (pad_val[0][OUT_W-1 -: 2] == 2'd0));
endmodule

bind tmr_wrapper tmr_wrapper_chk #(.CNT_W(CNT_W), .LAST(LAST)) u_chk (
    .clk        (clk_dom[0]),
    .rst_n      (rst_dom_n[0]),
    .pad_val    (pad_val),
    .pad_oe     (pad_oe),
    .upset_flag (upset_flag)
);

// File: tb/sim_tmr_wrapper.sv
// Directed bench for tmr_wrapper; models the joined board trace.
module sim_tmr_wrapper;
    localparam int CNT_W = 4;
    localparam int LAST  = 5;
    localparam int OW    = 2 + CNT_W;

    logic                 clk = 1'b0;
    logic [2:0]           clk_dom;
    logic [2:0]           rst_dom_n = 3'b000;
    logic [2:0]           start_pin = 3'b000;
    logic [2:0][OW-1:0]   pad_val;
    logic [2:0]           pad_oe;
    logic [2:0]           upset_flag;
    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;
    assign clk_dom = {3{clk}};

    tmr_wrapper #(.CNT_W(CNT_W), .LAST(LAST)) u0 (
        .clk_dom(clk_dom), .rst_dom_n(rst_dom_n), .start_pin(start_pin),
        .pad_val(pad_val), .pad_oe(pad_oe), .upset_flag(upset_flag)
    );

    function automatic logic [OW-1:0] pk(input int ph, input int c);
        return {ph[1:0], c[CNT_W-1:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Resolve the three pad groups as one wired trace and compare it.
    task automatic trace_chk(input string tag, input logic [OW-1:0] exp);
        int n = 0;
        bit clash = 0;
        logic [OW-1:0] v = '0;
        for (int i = 0; i < 3; i++) begin
            if (pad_oe[i]) begin
                if (n > 0 && pad_val[i] !== v) clash = 1;
                v = pad_val[i];
                n++;
            end
        end
        n_cmp++;
        if (n == 0 || clash || v !== exp) begin
            n_bad++;
            $display("FAIL %s: trace actual %0h (drivers %0d clash %0d) expected %0h",
                     tag, v, n, clash, exp);
        end
    endtask

    task automatic all_chk(input string tag, input logic [OW-1:0] exp);
        for (int i = 0; i < 3; i++) chk(tag, 32'(pad_val[i]), 32'(exp));
        chk(tag, 32'(pad_oe), 32'h7);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_dom_n = 3'b000;
        start_pin = 3'b000;
        repeat (2) @(negedge clk);
        rst_dom_n = 3'b111;
        all_chk("R1 reset value", pk(0, 0));
        chk("R1 flags cleared", 32'(upset_flag), 32'h0);
    endtask

    // Start all domains; returns at the negedge showing running, count 0.
    task automatic go_run();
        start_pin = 3'b111;
        @(negedge clk); trace_chk("R2 sync stage 1", pk(0, 0));
        @(negedge clk); trace_chk("R2 sync stage 2", pk(0, 0));
        @(negedge clk); all_chk("R2 run entry", pk(1, 0));
        start_pin = 3'b000;
    endtask

    task automatic t_sequence();
        go_run();
        for (int c = 1; c <= LAST; c++) begin
            @(negedge clk); all_chk("R3 count step", pk(1, c));
        end
        @(negedge clk); all_chk("R3 done phase", pk(2, LAST));
        @(negedge clk); all_chk("R3 back to idle", pk(0, 0));
        @(negedge clk); trace_chk("R3 idle holds", pk(0, 0));
    endtask

    task automatic t_start_in_run();
        go_run();
        @(negedge clk); start_pin = 3'b111;
        @(negedge clk); start_pin = 3'b000;
        trace_chk("R9 count 2", pk(1, 2));
        for (int c = 3; c <= LAST; c++) begin
            @(negedge clk); all_chk("R9 count unaffected", pk(1, c));
        end
        @(negedge clk); trace_chk("R9 done", pk(2, LAST));
        @(negedge clk); trace_chk("R9 idle", pk(0, 0));
        @(negedge clk); trace_chk("R9 stays idle", pk(0, 0));
    endtask

    task automatic t_glitch();
        @(negedge clk); start_pin = 3'b100;
        @(negedge clk); start_pin = 3'b000;
        trace_chk("R8 pre", pk(0, 0));
        @(negedge clk); trace_chk("R8 pre", pk(0, 0));
        @(negedge clk);
        chk("R8 lone copy moved", 32'(pad_val[2]), 32'(pk(1, 0)));
        chk("R8 lone copy disabled", 32'(pad_oe), 32'h3);
        trace_chk("R8 trace held", pk(0, 0));
        @(negedge clk);
        all_chk("R8 realigned", pk(0, 0));
        chk("R8 R7 flag of domain 2", 32'(upset_flag), 32'h4);
    endtask

    task automatic t_upset();
        go_run();
        @(negedge clk);
        @(negedge clk);
        force u0.g_dom[1].u_copy.cnt_q = 4'd3;
        #1;
        chk("R5 minority off", 32'(pad_oe), 32'h5);
        chk("R5 faulty value", 32'(pad_val[1]), 32'(pk(1, 3)));
        trace_chk("R5 trace held", pk(1, 2));
        #1 release u0.g_dom[1].u_copy.cnt_q;
        @(negedge clk);
        all_chk("R4 resync", pk(1, 3));
        chk("R7 flag set", 32'(upset_flag), 32'h2);
        @(negedge clk);
        chk("R7 flag sticky", 32'(upset_flag), 32'h2);
    endtask

    // Upset coinciding with the end-of-count transition.
    task automatic t_coincide();
        @(negedge clk);
        trace_chk("R3 at last", pk(1, LAST));
        force u0.g_dom[0].u_copy.cnt_q = 4'd4;
        #1;
        chk("R5 domain 0 off", 32'(pad_oe), 32'h6);
        trace_chk("R5 trace at last", pk(1, LAST));
        #1 release u0.g_dom[0].u_copy.cnt_q;
        @(negedge clk);
        all_chk("R4 joins done", pk(2, LAST));
        chk("R7 flags", 32'(upset_flag), 32'h3);
        @(negedge clk);
        all_chk("R3 idle after", pk(0, 0));
    endtask

    task automatic t_double();
        go_run();
        @(negedge clk);
        @(negedge clk);
        force u0.g_dom[0].u_copy.cnt_q = 4'd3;
        force u0.g_dom[1].u_copy.cnt_q = 4'd6;
        #1;
        chk("R6 all off", 32'(pad_oe), 32'h0);
        #1;
        release u0.g_dom[0].u_copy.cnt_q;
        release u0.g_dom[1].u_copy.cnt_q;
        @(negedge clk);
        all_chk("R4 bitwise vote rebuilds", pk(1, 3));
        chk("R7 two flags", 32'(upset_flag), 32'h3);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        t_reset();
        t_sequence();
        t_start_in_run();
        t_reset();
        t_glitch();
        t_reset();
        t_upset();
        t_coincide();
        t_reset();
        t_double();
        t_reset();
        finish_run();
    end
endmodule